// File: doc/BRIEF.md
# Dual-Depth Bitmap Pixel Serializer

This block turns framebuffer bytes into one pixel code per dot clock. It has two bitmap depths, and both use the same raster timing. In the colour depth, a byte holds four 2-bit pixels and each pixel is shown for two dot clocks. In the monochrome depth, a byte holds eight on/off pixels and each pixel is shown for one dot clock. Either way, one byte fills exactly eight dot clocks. The line therefore uses the same number of bytes in both depths. Each pixel is one scanline tall. Pixels leave most-significant first.

Bytes arrive on a valid/ready input. The ready signal follows the display-enable input: while display is enabled the block never pushes back, and a byte offered on any cycle is taken. A byte taken before the current one has finished replaces what is left of the current one. While display is disabled, ready is low, offered bytes are not taken, the output is forced to the background code, and any partly shifted byte is dropped. The pixel output is a plain stream with a valid flag. It has no ready, because a raster cannot wait.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pix_code` is 0 and `pix_valid` is 0.
- R2: With `mode_hires`=1 captured, the byte's bits go out MSB first, one per dot clock, as `pix_code` = {0, bit}, with `pix_valid`=1.
- R3: With `mode_hires`=0 captured, the byte's four 2-bit fields go out MSB first (bits 7:6, then 5:4, then 3:2, then 1:0), each held for two dot clocks.
- R4: A byte accepted at a clock edge drives its first pixel during the cycle that follows that edge.
- R5: A byte lasts exactly eight dot clocks. If no new byte is accepted by then, `pix_code` returns to 0 and `pix_valid` to 0.
- R6: A byte accepted while another is still in progress discards the rest of the older byte. The new byte's first pixel follows on the next cycle.
- R7: While `disp_en` is 0, `pix_code` is 0 and `pix_valid` is 0 in the same cycle. A byte that was partly shifted is discarded, so output stays 0 after `disp_en` returns unless a new byte is accepted.
- R8: `in_ready` equals `disp_en`. A byte offered while `disp_en` is 0 is not taken and produces no pixels.
- R9: The depth is captured from `mode_hires` when a byte is accepted. Changing `mode_hires` in the middle of a byte has no effect until the next byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | Display enable; low blanks the output |
| mode_hires | input | 1 | 1: eight 1-bit pixels per byte; 0: four 2-bit pixels per byte |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| in_data | input | DATA_W | Framebuffer byte |
| pix_code | output | 2 | Pixel code, 0 is background |
| pix_valid | output | 1 | An active pixel of a byte is on pix_code |

## Verification
A byte accepted at a rising edge has its first pixel due in the cycle that follows. The pixel at position i is due i cycles after that. The checks run on the falling edge right after each loading edge, so each registered result has settled and no new input has yet been applied. Blanking acts through combinational logic, so the bench checks it one nanosecond after it lowers `disp_en`. It checks the discard on the falling edge after the next rising edge. Bytes in the vector table are loaded back to back, so the step from the eighth dot of one byte to the first dot of the next is checked with no gap.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  typedef enum logic {
    PXS_COLOR = 1'b0,
    PXS_MONO  = 1'b1
  } pxs_mode_e;

  localparam int unsigned PXS_CODE_W = 2;
endpackage

// File: rtl/pxs_dot_timer.sv
module pxs_dot_timer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_en,
  input  logic                      load,
  output logic [$clog2(DATA_W)-1:0] dot_idx,
  output logic                      active,
  output logic                      last_dot
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_idx <= '0;
      active  <= 1'b0;
    end else if (!disp_en) begin
      dot_idx <= '0;
      active  <= 1'b0;
    end else if (load) begin
      dot_idx <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (last_dot) begin
        dot_idx <= '0;
        active  <= 1'b0;
      end else begin
        dot_idx <= dot_idx + 1'b1;
      end
    end
  end

  assign last_dot = active && (dot_idx == LAST_IDX);

  // R4
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && load) |=> (active && dot_idx == '0));

  // R5
  byte_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && last_dot && !load) |=> !active);
endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter
  import pxs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            disp_en,
  input  logic                            load,
  input  logic [DATA_W-1:0]               data,
  input  pxs_mode_e                       mode_in,
  input  logic                            active,
  input  logic                            last_dot,
  input  logic                            odd_dot,
  output logic [PXS_CODE_W-1:0]           top_bits,
  output pxs_mode_e                       mode_q
);
  logic [DATA_W-1:0] sreg;
  logic              step;

  // Colour pixels advance every second dot; mono pixels every dot.
  assign step = active && !last_dot && ((mode_q == PXS_MONO) || odd_dot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      mode_q <= PXS_COLOR;
    end else if (!disp_en) begin
      sreg   <= '0;
    end else if (load) begin
      sreg   <= data;
      mode_q <= mode_in;
    end else if (last_dot) begin
      sreg   <= '0;
    end else if (step) begin
      if (mode_q == PXS_MONO) sreg <= sreg << 1;
      else                    sreg <= sreg << PXS_CODE_W;
    end
  end

  assign top_bits = sreg[DATA_W-1 -: PXS_CODE_W];

  // R2
  mono_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && active && !last_dot && !load && mode_q == PXS_MONO)
      |=> (sreg[DATA_W-1] == $past(sreg[DATA_W-2])));

  // R3
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && active && !odd_dot && !load && mode_q == PXS_COLOR)
      |=> $stable(sreg));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q));
endmodule

// File: rtl/pxs_out_stage.sv
module pxs_out_stage
  import pxs_pkg::*;
(
  input  logic                  disp_en,
  input  logic                  active,
  input  pxs_mode_e             mode_q,
  input  logic [PXS_CODE_W-1:0] top_bits,
  output logic [PXS_CODE_W-1:0] pix_code,
  output logic                  pix_valid
);
  logic [PXS_CODE_W-1:0] raw_code;

  always_comb begin
    if (mode_q == PXS_MONO) raw_code = {{(PXS_CODE_W-1){1'b0}}, top_bits[PXS_CODE_W-1]};
    else                    raw_code = top_bits;
  end

  assign pix_valid = disp_en && active;
  assign pix_code  = pix_valid ? raw_code : '0;
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pxs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic              mode_hires,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [1:0]        pix_code,
  output logic              pix_valid
);
  localparam int unsigned CW = $clog2(DATA_W);

  logic                  load;
  logic [CW-1:0]         dot_idx;
  logic                  active;
  logic                  last_dot;
  logic [PXS_CODE_W-1:0] top_bits;
  pxs_mode_e             mode_q;
  pxs_mode_e             mode_in;

  assign in_ready = disp_en;
  assign load     = in_valid && in_ready;
  assign mode_in  = mode_hires ? PXS_MONO : PXS_COLOR;

  pxs_dot_timer #(.DATA_W(DATA_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .disp_en  (disp_en),
    .load     (load),
    .dot_idx  (dot_idx),
    .active   (active),
    .last_dot (last_dot)
  );

  pxs_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .disp_en  (disp_en),
    .load     (load),
    .data     (in_data),
    .mode_in  (mode_in),
    .active   (active),
    .last_dot (last_dot),
    .odd_dot  (dot_idx[0]),
    .top_bits (top_bits),
    .mode_q   (mode_q)
  );

  pxs_out_stage out_i (
    .disp_en   (disp_en),
    .active    (active),
    .mode_q    (mode_q),
    .top_bits  (top_bits),
    .pix_code  (pix_code),
    .pix_valid (pix_valid)
  );

  // R7
  blank_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> !pix_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (pix_code == 2'b00 && !pix_valid));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && active) |=> (active && pix_valid));
endmodule

// File: tb/pixel_serializer_tb.sv
`timescale 1ns/1ps
module pixel_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_en = 1'b1;
  logic       mode_hires = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] pix_code;
  logic       pix_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pixel_serializer #(.DATA_W(8)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_en    (disp_en),
    .mode_hires (mode_hires),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .pix_code   (pix_code),
    .pix_valid  (pix_valid)
  );

  // {mode_hires, byte}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'hA5}, {1'b0, 8'hE4}, {1'b1, 8'h80},
    {1'b0, 8'h1B}, {1'b1, 8'hFF}, {1'b0, 8'h3C}
  };

  function automatic logic [1:0] exp_pix(input logic m, input logic [7:0] d, input int i);
    if (m) return {1'b0, d[7-i]};
    return d[7-2*(i>>1) -: 2];
  endfunction

  task automatic check(input string req, input logic [1:0] got_c, input logic [1:0] exp_c,
                       input logic got_v, input logic exp_v);
    n_run++;
    if (got_c !== exp_c || got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: code=%0d valid=%0b expected code=%0d valid=%0b",
               req, got_c, got_v, exp_c, exp_v);
    end
  endtask

  task automatic offer(input logic m, input logic [7:0] d);
    in_valid = 1'b1; in_data = d; mode_hires = m;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", pix_code, 2'd0, pix_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", pix_code, 2'd0, pix_valid, 1'b0);
    n_run++;
    if (in_ready !== 1'b1) begin
      n_fail++; $display("FAIL R8: in_ready=%0b expected 1", in_ready);
    end

    // R2 R3 R4 R5: table walked back to back
    offer(VEC[0][8], VEC[0][7:0]);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (i == 0) in_valid = 1'b0;
        check(VEC[k][8] ? "R2 mono dot" : "R3 colour dot",
              pix_code, exp_pix(VEC[k][8], VEC[k][7:0], i), pix_valid, 1'b1);
        if (i == 7 && k < 5) offer(VEC[k+1][8], VEC[k+1][7:0]);
      end
    end
    @(negedge clk);
    check("R5 idle after eight dots", pix_code, 2'd0, pix_valid, 1'b0);

    // R6: mid-byte override
    offer(1'b1, 8'hF0);
    @(negedge clk); in_valid = 1'b0;
    check("R4 first dot", pix_code, 2'd1, pix_valid, 1'b1);
    @(negedge clk);
    check("R6 before override", pix_code, 2'd1, pix_valid, 1'b1);
    offer(1'b0, 8'h9B);
    @(negedge clk); in_valid = 1'b0;
    check("R6 new byte dot0", pix_code, 2'd2, pix_valid, 1'b1);
    @(negedge clk);
    check("R6 new byte dot1", pix_code, 2'd2, pix_valid, 1'b1);
    @(negedge clk);
    check("R6 new byte dot2", pix_code, 2'd1, pix_valid, 1'b1);

    // R7 R8: blanking and discard
    repeat (6) @(negedge clk);
    offer(1'b1, 8'hFF);
    @(negedge clk); in_valid = 1'b0;
    check("R7 pre-blank", pix_code, 2'd1, pix_valid, 1'b1);
    disp_en = 1'b0;
    #1;
    check("R7 blank same cycle", pix_code, 2'd0, pix_valid, 1'b0);
    n_run++;
    if (in_ready !== 1'b0) begin
      n_fail++; $display("FAIL R8: in_ready=%0b expected 0", in_ready);
    end
    offer(1'b1, 8'hFF);
    @(negedge clk);
    in_valid = 1'b0;
    disp_en = 1'b1;
    #1;
    check("R7 R8 nothing after blank", pix_code, 2'd0, pix_valid, 1'b0);
    @(negedge clk);
    check("R7 R8 still idle", pix_code, 2'd0, pix_valid, 1'b0);

    // R9: mode captured at load
    offer(1'b0, 8'hE4);
    @(negedge clk); in_valid = 1'b0;
    check("R9 dot0", pix_code, 2'd3, pix_valid, 1'b1);
    mode_hires = 1'b1;
    @(negedge clk);
    check("R9 dot1 after mode change", pix_code, 2'd3, pix_valid, 1'b1);
    @(negedge clk);
    check("R9 dot2 after mode change", pix_code, 2'd2, pix_valid, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule